// File: doc/BRIEF.md
# CCD Line and Frame Timing Generator

This block generates the digital enables that steer an interline, progressive-scan CCD through external level shifters. A master clock runs at a fixed multiple of the pixel rate. From it the block derives the following enables:
- the two complementary horizontal phases and the floating-diffusion reset pulse;
- the clamp and sample strobes used by correlated double sampling;
- vertical phase 1, and vertical phase 2 at its mid level;
- a separate enable that lifts vertical phase 2 to its third, high level, so that photodiode charge moves into the vertical registers once per frame.

It also emits line-start and frame-start markers and a per-pixel region tag (empty, active, dark) for the capture path downstream.

A frame is a fixed number of lines, and each line is a fixed number of master cycles. The first line of every frame is a readout line. In it, vertical phase 2 rests at mid level for a pedestal, goes high for a programmable time, then returns to mid level; there is no horizontal clocking in that line. Every other line starts with a row transfer window, in which phase 2 is low and phase 1 is high. A horizontal delay follows, and then the pixel burst. All programmable durations are given in master cycles. They are sampled into shadow registers only at the frame boundary, so a frame never mixes old and new settings.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst` is high, and in the output cycle it drives at reset, the outputs are idle: `vPhase2Mid`=1, `vPhase1`=0, `vPhase2High`=0, `hClk1`=1, `hClk2`=0, and `fdReset`, `clampStb`, `sampleStb`, `lineStart`, `frameStart` are 0 with `pixRegion`=0.
- R2: `lineStart` is high for one cycle every LINE_CYC cycles. The first of these is the first cycle after reset is released. `frameStart` is high only together with the `lineStart` of every FRAME_LINES-th line, starting with the first one.
- R3: In every line except the readout line, `vPhase1` is high, and phase 2 is low (`vPhase2Mid`=0, `vPhase2High`=0), for line cycles 0 to cfgXferLen-1. Outside that window `vPhase1` is low. In every cycle exactly one of `vPhase1`, `vPhase2Mid`, `vPhase2High` is high.
- R4: In non-readout lines, horizontal clocking starts at line cycle cfgXferLen+cfgHDelay, where a cfgHDelay of 0 counts as 1. It lasts TOTAL_PIX×PIX_SUB cycles. Within each pixel, `hClk2` is high for the first PIX_SUB/2 sub-cycles and `hClk1` is always its complement. Outside the burst, `hClk2`=0 and `hClk1`=1.
- R5: `fdReset` is high for the first RST_CYC (2) sub-cycles of every clocked pixel, so it rises in the same cycle as `hClk2`. It is low otherwise.
- R6: `clampStb` is high in the sub-cycle equal to cfgClampOfs, and `sampleStb` in the sub-cycle equal to cfgSampleOfs, of every clocked pixel. Both may select the same sub-cycle. Neither is ever high outside the burst.
- R7: `pixRegion` reads 0 outside the burst. Inside it, pixel index p (counting from 0) reads 1 (empty) for p < EMPTY_PIX, 2 (active) for the next ACTIVE_PIX pixels, 3 (dark) for the next DARK_PIX pixels, and 1 (empty) for the trailing TRAIL_PIX pixels.
- R8: In the readout line, `vPhase2High` is high for line cycles cfgPedLen to cfgPedLen+cfgReadLen-1 and `vPhase2Mid` is high for the remaining cycles. There is no transfer window and no horizontal clocking in that line.
- R9: A configuration input changed during a frame takes effect only from the next frame start. The current frame keeps the values it began with.
- R10: While `pixRegion` is nonzero, `vPhase1` and `vPhase2High` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, PIX_SUB times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| cfgXferLen | input | CYC_W | Row transfer window length, master cycles |
| cfgHDelay | input | CYC_W | Gap from end of transfer to first pixel (0 treated as 1) |
| cfgPedLen | input | CYC_W | Pedestal before the high-level readout pulse |
| cfgReadLen | input | CYC_W | Duration of the high-level readout pulse |
| cfgClampOfs | input | SUB_W | Sub-cycle of the clamp strobe within a pixel |
| cfgSampleOfs | input | SUB_W | Sub-cycle of the sample strobe within a pixel |
| hClk1 | output | 1 | Horizontal phase 1 enable |
| hClk2 | output | 1 | Horizontal phase 2 enable |
| fdReset | output | 1 | Floating-diffusion reset pulse |
| clampStb | output | 1 | Reference clamp strobe |
| sampleStb | output | 1 | Signal sample strobe |
| vPhase1 | output | 1 | Vertical phase 1 high |
| vPhase2Mid | output | 1 | Vertical phase 2 at mid level |
| vPhase2High | output | 1 | Vertical phase 2 at high (readout) level |
| lineStart | output | 1 | First cycle of a line |
| frameStart | output | 1 | First cycle of a frame |
| pixRegion | output | 2 | 0 none, 1 empty, 2 active, 3 dark |

## Verification
The block is driven with three configurations, each compared against a cycle-accurate reference for whole frames.
- The first has a non-zero horizontal delay, distinct clamp and sample offsets and a non-zero pedestal.
- The second uses a zero horizontal delay, to exercise the minimum gap, and places the strobes at the first and last sub-cycles.
- The third uses a one-cycle transfer window, no pedestal, a single-cycle readout pulse and coinciding strobes.

A configuration written in mid-frame separates a design that latches settings at the frame boundary from one that applies them immediately. A reset asserted in mid-frame shows that every phase returns to idle and that the sequence restarts at the readout line.

// File: rtl/ccdtg_pkg.sv
`timescale 1ns/1ps
package ccdtg_pkg;

  // Region tag carried with every master cycle of a line.
  typedef enum logic [1:0] {
    REG_IDLE   = 2'd0,
    REG_EMPTY  = 2'd1,
    REG_ACTIVE = 2'd2,
    REG_DARK   = 2'd3
  } pixRegion_e;

  // Strobes from the sequencer to the waveform register bank.
  typedef struct packed {
    logic lineStart;
    logic frameStart;
    logic xferWin;
    logic vHighWin;
    logic hRun;
    logic h2Win;
    logic rstWin;
    logic clampHit;
    logic sampleHit;
  } ccdStrobe_t;

endpackage

// File: rtl/ccdtg_ctrl.sv
`timescale 1ns/1ps
module ccdtg_ctrl #(
  parameter int LINE_CYC    = 7275,
  parameter int FRAME_LINES = 525,
  parameter int PIX_SUB     = 8,
  parameter int TOTAL_PIX   = 791,
  parameter int RST_CYC     = 2,
  parameter int CYC_W       = 13,
  parameter int SUB_W       = 3,
  parameter int PIX_W       = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CYC_W-1:0]       cfgXferLen,
  input  logic [CYC_W-1:0]       cfgHDelay,
  input  logic [CYC_W-1:0]       cfgPedLen,
  input  logic [CYC_W-1:0]       cfgReadLen,
  input  logic [SUB_W-1:0]       cfgClampOfs,
  input  logic [SUB_W-1:0]       cfgSampleOfs,
  output ccdtg_pkg::ccdStrobe_t  stb,
  output logic [PIX_W-1:0]       pixCnt
);
  localparam int LN_W = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;

  logic [CYC_W-1:0] lineCyc;
  logic [LN_W-1:0]  lineNum;

  // Frame-atomic shadow copies of the configuration.
  logic [CYC_W-1:0] xferS, hDlyS, pedS, readS;
  logic [SUB_W-1:0] clampS, sampS;

  logic             hRun;
  logic [SUB_W-1:0] subCnt;

  logic lineEnd, frameEnd, readLine, hBegin;
  logic [CYC_W:0] hStart, vhEnd, cycNext;

  assign lineEnd  = (lineCyc == CYC_W'(LINE_CYC - 1));
  assign frameEnd = lineEnd && (lineNum == LN_W'(FRAME_LINES - 1));
  assign readLine = (lineNum == '0);

  assign hStart  = {1'b0, xferS} + ((hDlyS == '0) ? (CYC_W+1)'(1) : {1'b0, hDlyS});
  assign vhEnd   = {1'b0, pedS} + {1'b0, readS};
  assign cycNext = {1'b0, lineCyc} + (CYC_W+1)'(1);
  assign hBegin  = !readLine && !lineEnd && (cycNext == hStart);

  // Line and frame position.
  always_ff @(posedge clk) begin
    if (rst) begin
      lineCyc <= '0;
      lineNum <= '0;
    end else begin
      lineCyc <= lineEnd ? '0 : lineCyc + CYC_W'(1);
      if (lineEnd)
        lineNum <= frameEnd ? '0 : lineNum + LN_W'(1);
    end
  end

  // Settings are captured in reset and at the last cycle of each frame.
  always_ff @(posedge clk) begin
    if (rst || frameEnd) begin
      xferS  <= cfgXferLen;
      hDlyS  <= cfgHDelay;
      pedS   <= cfgPedLen;
      readS  <= cfgReadLen;
      clampS <= cfgClampOfs;
      sampS  <= cfgSampleOfs;
    end
  end

  // Pixel burst: sub-cycle and pixel counters run only inside the burst.
  always_ff @(posedge clk) begin
    if (rst) begin
      hRun   <= 1'b0;
      subCnt <= '0;
      pixCnt <= '0;
    end else if (lineEnd) begin
      hRun   <= 1'b0;
      subCnt <= '0;
      pixCnt <= '0;
    end else if (hBegin) begin
      hRun   <= 1'b1;
      subCnt <= '0;
      pixCnt <= '0;
    end else if (hRun) begin
      if (subCnt == SUB_W'(PIX_SUB - 1)) begin
        subCnt <= '0;
        if (pixCnt == PIX_W'(TOTAL_PIX - 1))
          hRun <= 1'b0;
        else
          pixCnt <= pixCnt + PIX_W'(1);
      end else begin
        subCnt <= subCnt + SUB_W'(1);
      end
    end
  end

  always_comb begin
    stb.lineStart  = (lineCyc == '0);
    stb.frameStart = (lineCyc == '0) && readLine;
    stb.xferWin    = !readLine && (lineCyc < xferS);
    stb.vHighWin   = readLine && ({1'b0, lineCyc} >= {1'b0, pedS})
                              && ({1'b0, lineCyc} < vhEnd);
    stb.hRun       = hRun;
    stb.h2Win      = hRun && (subCnt < SUB_W'(PIX_SUB / 2));
    stb.rstWin     = hRun && (subCnt < SUB_W'(RST_CYC));
    stb.clampHit   = hRun && (subCnt == clampS);
    stb.sampleHit  = hRun && (subCnt == sampS);
  end

endmodule

// File: rtl/ccdtg_wave.sv
`timescale 1ns/1ps
module ccdtg_wave #(
  parameter int EMPTY_PIX  = 9,
  parameter int ACTIVE_PIX = 768,
  parameter int DARK_PIX   = 12,
  parameter int PIX_W      = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ccdtg_pkg::ccdStrobe_t stb,
  input  logic [PIX_W-1:0]      pixCnt,
  output logic                  hClk1,
  output logic                  hClk2,
  output logic                  fdReset,
  output logic                  clampStb,
  output logic                  sampleStb,
  output logic                  vPhase1,
  output logic                  vPhase2Mid,
  output logic                  vPhase2High,
  output logic                  lineStart,
  output logic                  frameStart,
  output logic [1:0]            pixRegion
);
  import ccdtg_pkg::*;

  localparam int ACT_LO  = EMPTY_PIX;
  localparam int DARK_LO = EMPTY_PIX + ACTIVE_PIX;
  localparam int TRL_LO  = EMPTY_PIX + ACTIVE_PIX + DARK_PIX;

  pixRegion_e regionNext;

  always_comb begin
    if (!stb.hRun)
      regionNext = REG_IDLE;
    else if ({1'b0, pixCnt} < (PIX_W+1)'(ACT_LO))
      regionNext = REG_EMPTY;
    else if ({1'b0, pixCnt} < (PIX_W+1)'(DARK_LO))
      regionNext = REG_ACTIVE;
    else if ({1'b0, pixCnt} < (PIX_W+1)'(TRL_LO))
      regionNext = REG_DARK;
    else
      regionNext = REG_EMPTY;
  end

  // Every pin comes straight from a flop: no decode glitches reach the drivers.
  always_ff @(posedge clk) begin
    if (rst) begin
      hClk1       <= 1'b1;
      hClk2       <= 1'b0;
      fdReset     <= 1'b0;
      clampStb    <= 1'b0;
      sampleStb   <= 1'b0;
      vPhase1     <= 1'b0;
      vPhase2Mid  <= 1'b1;
      vPhase2High <= 1'b0;
      lineStart   <= 1'b0;
      frameStart  <= 1'b0;
      pixRegion   <= REG_IDLE;
    end else begin
      hClk1       <= !stb.h2Win;
      hClk2       <= stb.h2Win;
      fdReset     <= stb.rstWin;
      clampStb    <= stb.clampHit;
      sampleStb   <= stb.sampleHit;
      vPhase1     <= stb.xferWin;
      vPhase2High <= stb.vHighWin;
      vPhase2Mid  <= !stb.xferWin && !stb.vHighWin;
      lineStart   <= stb.lineStart;
      frameStart  <= stb.frameStart;
      pixRegion   <= regionNext;
    end
  end

endmodule

// File: rtl/ccd_timing_gen.sv
`timescale 1ns/1ps
module ccd_timing_gen #(
  parameter int LINE_CYC    = 7275,
  parameter int FRAME_LINES = 525,
  parameter int PIX_SUB     = 8,
  parameter int EMPTY_PIX   = 9,
  parameter int ACTIVE_PIX  = 768,
  parameter int DARK_PIX    = 12,
  parameter int TRAIL_PIX   = 2,
  parameter int RST_CYC     = 2,
  localparam int TOTAL_PIX  = EMPTY_PIX + ACTIVE_PIX + DARK_PIX + TRAIL_PIX,
  localparam int CYC_W      = $clog2(LINE_CYC),
  localparam int SUB_W      = $clog2(PIX_SUB),
  localparam int PIX_W      = $clog2(TOTAL_PIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] cfgXferLen,
  input  logic [CYC_W-1:0] cfgHDelay,
  input  logic [CYC_W-1:0] cfgPedLen,
  input  logic [CYC_W-1:0] cfgReadLen,
  input  logic [SUB_W-1:0] cfgClampOfs,
  input  logic [SUB_W-1:0] cfgSampleOfs,
  output logic             hClk1,
  output logic             hClk2,
  output logic             fdReset,
  output logic             clampStb,
  output logic             sampleStb,
  output logic             vPhase1,
  output logic             vPhase2Mid,
  output logic             vPhase2High,
  output logic             lineStart,
  output logic             frameStart,
  output logic [1:0]       pixRegion
);
  ccdtg_pkg::ccdStrobe_t stb;
  logic [PIX_W-1:0]      pixCnt;

  ccdtg_ctrl #(
    .LINE_CYC(LINE_CYC), .FRAME_LINES(FRAME_LINES), .PIX_SUB(PIX_SUB),
    .TOTAL_PIX(TOTAL_PIX), .RST_CYC(RST_CYC),
    .CYC_W(CYC_W), .SUB_W(SUB_W), .PIX_W(PIX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgXferLen(cfgXferLen), .cfgHDelay(cfgHDelay),
    .cfgPedLen(cfgPedLen), .cfgReadLen(cfgReadLen),
    .cfgClampOfs(cfgClampOfs), .cfgSampleOfs(cfgSampleOfs),
    .stb(stb), .pixCnt(pixCnt)
  );

  ccdtg_wave #(
    .EMPTY_PIX(EMPTY_PIX), .ACTIVE_PIX(ACTIVE_PIX),
    .DARK_PIX(DARK_PIX), .PIX_W(PIX_W)
  ) u_wave (
    .clk(clk), .rst(rst), .stb(stb), .pixCnt(pixCnt),
    .hClk1(hClk1), .hClk2(hClk2), .fdReset(fdReset),
    .clampStb(clampStb), .sampleStb(sampleStb),
    .vPhase1(vPhase1), .vPhase2Mid(vPhase2Mid), .vPhase2High(vPhase2High),
    .lineStart(lineStart), .frameStart(frameStart), .pixRegion(pixRegion)
  );

endmodule

// File: rtl/ccdtg_checker.sv
`timescale 1ns/1ps
module ccdtg_checker (
  input logic       clk,
  input logic       rst,
  input logic       hClk1,
  input logic       hClk2,
  input logic       fdReset,
  input logic       clampStb,
  input logic       sampleStb,
  input logic       vPhase1,
  input logic       vPhase2Mid,
  input logic       vPhase2High,
  input logic       lineStart,
  input logic       frameStart,
  input logic [1:0] pixRegion
);
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> lineStart); // R2

  AST_ONE_V_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $countones({vPhase1, vPhase2Mid, vPhase2High}) == 1); // R3

  AST_H_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    hClk1 != hClk2); // R4

  AST_H_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (pixRegion == 2'd0) |-> (hClk1 && !hClk2)); // R4

  AST_RST_WITH_H2: assert property (@(posedge clk) disable iff (rst)
    $rose(hClk2) |-> $rose(fdReset)); // R5

  AST_RST_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(fdReset) |=> fdReset); // R5

  AST_RST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (fdReset && $past(fdReset)) |=> !fdReset); // R5

  AST_STROBE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    (clampStb || sampleStb) |-> (pixRegion != 2'd0)); // R6

  AST_READOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    vPhase2High |-> (pixRegion == 2'd0 && !hClk2)); // R8

  AST_V_QUIET_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    (pixRegion != 2'd0) |-> (!vPhase1 && !vPhase2High)); // R10

endmodule

bind ccd_timing_gen ccdtg_checker u_ccdtg_checker (
  .clk(clk), .rst(rst), .hClk1(hClk1), .hClk2(hClk2), .fdReset(fdReset),
  .clampStb(clampStb), .sampleStb(sampleStb), .vPhase1(vPhase1),
  .vPhase2Mid(vPhase2Mid), .vPhase2High(vPhase2High),
  .lineStart(lineStart), .frameStart(frameStart), .pixRegion(pixRegion)
);

// File: tb/tb_ccd_timing_gen.sv
`timescale 1ns/1ps
module tb_ccd_timing_gen;
  localparam int LC    = 160;
  localparam int FL    = 4;
  localparam int SUB   = 8;
  localparam int EMP   = 2;
  localparam int ACT   = 6;
  localparam int DRK   = 3;
  localparam int TRL   = 1;
  localparam int TOT   = EMP + ACT + DRK + TRL;
  localparam int CW    = $clog2(LC);
  localparam int SW    = $clog2(SUB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfgXferLen = '0, cfgHDelay = '0, cfgPedLen = '0, cfgReadLen = '0;
  logic [SW-1:0] cfgClampOfs = '0, cfgSampleOfs = '0;
  logic hClk1, hClk2, fdReset, clampStb, sampleStb;
  logic vPhase1, vPhase2Mid, vPhase2High, lineStart, frameStart;
  logic [1:0] pixRegion;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference model state: counter position and frame-latched settings.
  int mLine, mCyc;
  int sXf, sHd, sPd, sRd, sCl, sSa;
  int oLine, oCyc, oXf, oHd, oPd, oRd, oCl, oSa;

  always #2.5 clk = ~clk;

  ccd_timing_gen #(
    .LINE_CYC(LC), .FRAME_LINES(FL), .PIX_SUB(SUB),
    .EMPTY_PIX(EMP), .ACTIVE_PIX(ACT), .DARK_PIX(DRK), .TRAIL_PIX(TRL)
  ) dut (
    .clk(clk), .rst(rst),
    .cfgXferLen(cfgXferLen), .cfgHDelay(cfgHDelay),
    .cfgPedLen(cfgPedLen), .cfgReadLen(cfgReadLen),
    .cfgClampOfs(cfgClampOfs), .cfgSampleOfs(cfgSampleOfs),
    .hClk1(hClk1), .hClk2(hClk2), .fdReset(fdReset),
    .clampStb(clampStb), .sampleStb(sampleStb),
    .vPhase1(vPhase1), .vPhase2Mid(vPhase2Mid), .vPhase2High(vPhase2High),
    .lineStart(lineStart), .frameStart(frameStart), .pixRegion(pixRegion)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      if (fails <= 40)
        $display("FAIL %s actual=%0d expected=%0d (line %0d cycle %0d)",
                 tag, act, exp, oLine, oCyc);
    end
  endtask

  task automatic setCfg(input int xf, input int hd, input int pd, input int rd,
                        input int cl, input int sa);
    cfgXferLen   = CW'(xf);
    cfgHDelay    = CW'(hd);
    cfgPedLen    = CW'(pd);
    cfgReadLen   = CW'(rd);
    cfgClampOfs  = SW'(cl);
    cfgSampleOfs = SW'(sa);
  endtask

  task automatic latchCfg();
    sXf = int'(cfgXferLen);  sHd = int'(cfgHDelay);
    sPd = int'(cfgPedLen);   sRd = int'(cfgReadLen);
    sCl = int'(cfgClampOfs); sSa = int'(cfgSampleOfs);
  endtask

  task automatic checkIdle(input string tag);
    chk({tag, " vPhase2Mid"}, int'(vPhase2Mid), 1);
    chk({tag, " vPhase1"}, int'(vPhase1), 0);
    chk({tag, " vPhase2High"}, int'(vPhase2High), 0);
    chk({tag, " hClk1"}, int'(hClk1), 1);
    chk({tag, " hClk2"}, int'(hClk2), 0);
    chk({tag, " strobes"}, int'({fdReset, clampStb, sampleStb, lineStart, frameStart}), 0);
    chk({tag, " pixRegion"}, int'(pixRegion), 0);
  endtask

  // One master cycle: model the edge, step, then compare every output.
  task automatic tick();
    bit rl, eV1, eVH, hr;
    int hs, off, s, p, eReg;
    oLine = mLine; oCyc = mCyc;
    oXf = sXf; oHd = sHd; oPd = sPd; oRd = sRd; oCl = sCl; oSa = sSa;
    if (mLine == FL-1 && mCyc == LC-1) latchCfg();
    if (mCyc == LC-1) begin
      mCyc = 0;
      mLine = (mLine == FL-1) ? 0 : mLine + 1;
    end else begin
      mCyc++;
    end
    @(posedge clk);
    @(negedge clk);
    rl  = (oLine == 0);
    eV1 = !rl && (oCyc < oXf);
    eVH = rl && (oCyc >= oPd) && (oCyc < oPd + oRd);
    hs  = oXf + ((oHd == 0) ? 1 : oHd);
    hr  = !rl && (oCyc >= hs) && (oCyc < hs + TOT*SUB);
    off = oCyc - hs;
    s   = hr ? (off % SUB) : 0;
    p   = hr ? (off / SUB) : 0;
    if (!hr)                  eReg = 0;
    else if (p < EMP)         eReg = 1;
    else if (p < EMP+ACT)     eReg = 2;
    else if (p < EMP+ACT+DRK) eReg = 3;
    else                      eReg = 1;
    chk("R2 lineStart", int'(lineStart), int'(oCyc == 0));
    chk("R2 frameStart", int'(frameStart), int'(oCyc == 0 && rl));
    chk("R3 vPhase1", int'(vPhase1), int'(eV1));
    chk("R8 vPhase2High", int'(vPhase2High), int'(eVH));
    chk("R3 vPhase2Mid", int'(vPhase2Mid), int'(!eV1 && !eVH));
    chk("R4 hClk2", int'(hClk2), int'(hr && s < SUB/2));
    chk("R4 hClk1", int'(hClk1), int'(!(hr && s < SUB/2)));
    chk("R5 fdReset", int'(fdReset), int'(hr && s < 2));
    chk("R6 clampStb", int'(clampStb), int'(hr && s == oCl));
    chk("R6 sampleStb", int'(sampleStb), int'(hr && s == oSa));
    chk("R7 pixRegion", int'(pixRegion), eReg);
    if (pixRegion != 2'd0)
      chk("R10 vertical quiet in burst", int'(vPhase1 || vPhase2High), 0);
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // R1: idle outputs while reset is held, then restart at the readout line.
  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkIdle("R1 in reset");
    end
    latchCfg();
    mLine = 0; mCyc = 0;
    rst = 1'b0;
  endtask

  // Baseline configuration over two full frames (R2..R8, R10).
  task automatic testBaseline();
    setCfg(6, 4, 5, 20, 2, 6);
    testReset();
    runCycles(2 * FL * LC);
  endtask

  // R9: settings written mid-frame wait for the next frame start.
  // This configuration also uses a zero horizontal delay (R4) and edge strobes (R6).
  task automatic testMidFrameCfg();
    int cnt;
    while (!(mLine == 2 && mCyc == 0)) tick();
    setCfg(12, 0, 3, 40, 0, 7);
    cnt = 0;
    while (!(mLine == 0 && mCyc == 0)) begin
      tick();
      if (oLine == 3 && vPhase1) cnt++;
    end
    tick();
    chk("R9 old transfer length kept in current frame", cnt, 6);
    cnt = 0;
    while (!(mLine == 2 && mCyc == 0)) begin
      tick();
      if (oLine == 1 && vPhase1) cnt++;
    end
    chk("R9 new transfer length after frame start", cnt, 12);
    runCycles(FL * LC);
  endtask

  // Short windows and coinciding strobes (R3, R6, R8), then a mid-frame reset (R1).
  task automatic testCorners();
    setCfg(1, 2, 0, 1, 3, 3);
    while (!(mLine == 0 && mCyc == 0)) tick();
    runCycles(2 * FL * LC);
    runCycles(LC + 37);
    testReset();
    tick();
    chk("R1 restart frameStart", int'(frameStart), 1);
    runCycles(FL * LC);
  endtask

  initial begin
    testBaseline();
    testMidFrameCfg();
    testCorners();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(1000000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule